// File: doc/BRIEF.md
# Performance Monitor Register Access Unit

This block owns the programmable state of a processor performance monitor: two control registers (CR0 and CR2, 64 bits each) and six 32-bit event counters. It serves move-to and move-from register requests. Each request carries a register number, a user/privileged flag, a write flag and write data. The answer is read data, or a one-cycle fault pulse with a cause code. Privileged software sees and writes every bit. User software works through a narrow window that a 2-bit access mode field in CR0 opens or closes.

In user mode, reads of CR0 and CR2 are filtered down to a few bits, and writes to them merge only the user-visible bits into the old value. The user numbers for the counters sit 0x10 below the privileged numbers. In the most open mode, counters 5 and 6 are withdrawn from user software. Each counter also counts its event input unless the freeze bit in CR0 is set.

Requests are accepted in any cycle. A small two-state machine produces the response:
- **ST_IDLE**: no response is presented.
- **ST_RESP**: the registered response of the request from the previous cycle is presented.

The machine has two transitions:
- **IDLE→RESP** and **RESP→RESP** on `req_valid`.
- **RESP→IDLE** and **IDLE→IDLE** when no request arrives.

Top module: `perfmon_access`

## Requirements
- R1: The response to a request accepted at a clock edge (`rsp_valid`=1 with its data and cause) is presented for exactly the following cycle. No response appears without a request, and none appears out of reset.
- R2: The access mode is CR0 bits 19:18. A user read of CR0, CR2 or any counter is allowed for mode 00, 10 and 11. In mode 01 it faults with cause 01 (facility unavailable).
- R3: User writes to CR0, CR2 or the counters behave by mode:
  - Mode 10 and mode 11: the write is allowed.
  - Mode 00: the write faults with cause 10 (emulation assist).
  - Mode 01: the write faults with cause 01.
- R4: In mode 11, any user read or write of counter 5 or 6 (user numbers 0x14, 0x15) faults with cause 01. Counters 1–4 stay accessible.
- R5: A user read of CR0 returns only bits 31 (freeze), 26 (alert enable) and 7 (alert occurred). All other bits read as zero.
- R6: A user read of CR2 returns only bits 13:8 (one user-state freeze bit per counter). All other bits read as zero.
- R7: A user write to CR0 or CR2 sets new = (old & ~mask) | (wdata & mask), with the masks of R5 and R6.
- R8: CR0 is number 0x30 and CR2 is number 0x32 in both modes. Counter k (1..6) is privileged number 0x1F+k and user number 0x0F+k.
- R9: Privileged accesses never fault and are unmasked. A counter write keeps wdata[31:0], and a counter read is zero-extended.
- R10: A faulting access changes no register and returns zero read data. The cause code is 00 when there is no fault.
- R11: A counter adds one per cycle while its event input is high, unless CR0 bit 31 is set. A write to the counter in the same cycle wins over the increment.
- R12: A number outside R8's map returns zero with no fault. This includes a user number used privileged and a privileged counter number used from user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one per cycle |
| req_write | input | 1 | 1 = move-to register, 0 = move-from |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| req_num | input | 8 | Register number |
| req_wdata | input | 64 | Write data |
| evt | input | 6 | Per-counter event inputs |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data (zero for writes and faults) |
| rsp_fault | output | 1 | Fault pulse |
| rsp_cause | output | 2 | 00 none, 01 facility unavailable, 10 emulation assist |

## Verification
The same register numbers are exercised under each of the four mode values, so that the read rule, the write rule and their two distinct fault causes can be told apart from one another. CR0 and CR2 writes are issued in user mode with all-ones and all-zeros data over preloaded privileged patterns; this separates masked merge from plain overwrite and from a dropped write. Counters 5 and 6 are touched in mode 11 next to counter 4, and the untouched value is then read back privileged to show that the faulting write did not land. Event bursts are run with the freeze bit clear and then set, and one counter write is made in the same cycle as an event, to show that the write has priority.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int NUM_W = 8;

    localparam logic [NUM_W-1:0] CR0_NUM        = 8'h30;
    localparam logic [NUM_W-1:0] CR2_NUM        = 8'h32;
    localparam logic [NUM_W-1:0] PRV_CNT_BASE   = 8'h20;
    localparam logic [NUM_W-1:0] USR_CNT_OFFSET = 8'h10;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_FACUNAV = 2'b01,
        CAUSE_EMUASST = 2'b10
    } cause_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_CR0,
        TGT_CR2,
        TGT_CNT
    } target_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } state_e;

endpackage

// File: rtl/perfmon_decode.sv
module perfmon_decode
    import perfmon_pkg::*;
#(
    parameter int N_CNT = 6,
    localparam int IDX_W = (N_CNT > 1) ? $clog2(N_CNT) : 1
) (
    input  logic [NUM_W-1:0] num,
    input  logic             user,
    output target_e          tgt,
    output logic [IDX_W-1:0] idx
);

    logic [NUM_W-1:0] cnt_base;
    logic [NUM_W-1:0] offset;

    always_comb begin
        cnt_base = user ? (PRV_CNT_BASE - USR_CNT_OFFSET) : PRV_CNT_BASE;
        offset   = num - cnt_base;
        tgt      = TGT_NONE;
        idx      = '0;
        if (num == CR0_NUM) begin
            tgt = TGT_CR0;
        end else if (num == CR2_NUM) begin
            tgt = TGT_CR2;
        end else if (offset < NUM_W'(N_CNT)) begin
            tgt = TGT_CNT;
            idx = offset[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/perfmon_gate.sv
module perfmon_gate
    import perfmon_pkg::*;
#(
    parameter int N_CNT  = 6,
    parameter int WD_LSB = 4,
    localparam int IDX_W = (N_CNT > 1) ? $clog2(N_CNT) : 1
) (
    input  target_e          tgt,
    input  logic [IDX_W-1:0] idx,
    input  logic             user,
    input  logic             write,
    input  logic [1:0]       mode,
    output cause_e           cause
);

    logic withdrawn;

    always_comb begin
        withdrawn = (tgt == TGT_CNT) && (mode == 2'b11) && (int'(idx) >= WD_LSB);
        cause     = CAUSE_NONE;
        if (user && (tgt != TGT_NONE)) begin
            if (withdrawn) begin
                cause = CAUSE_FACUNAV;
            end else if (mode == 2'b01) begin
                cause = CAUSE_FACUNAV;
            end else if (write && (mode == 2'b00)) begin
                cause = CAUSE_EMUASST;
            end
        end
    end

endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             frz,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_en) begin
            count <= wdata;
        end else if (evt && !frz) begin
            count <= count + 1'b1;
        end
    end

    // R11
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (frz || !evt)) |=> $stable(count));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wdata)));

endmodule

// File: rtl/perfmon_access.sv
module perfmon_access
    import perfmon_pkg::*;
#(
    parameter int REG_W       = 64,
    parameter int CNT_W       = 32,
    parameter int N_CNT       = 6,
    parameter int WD_LSB      = 4,
    parameter int FRZ_BIT     = 31,
    parameter int ALERT_BIT   = 7,
    parameter int ALERTEN_BIT = 26,
    parameter int MODE_LSB    = 18,
    parameter int CR2_USR_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_user,
    input  logic [NUM_W-1:0] req_num,
    input  logic [REG_W-1:0] req_wdata,
    input  logic [N_CNT-1:0] evt,
    output logic             rsp_valid,
    output logic [REG_W-1:0] rsp_rdata,
    output logic             rsp_fault,
    output logic [1:0]       rsp_cause
);

    localparam int IDX_W = (N_CNT > 1) ? $clog2(N_CNT) : 1;
    localparam logic [REG_W-1:0] CR0_UMASK = (REG_W'(1) << FRZ_BIT)
                                           | (REG_W'(1) << ALERT_BIT)
                                           | (REG_W'(1) << ALERTEN_BIT);
    localparam logic [REG_W-1:0] CR2_UMASK = ((REG_W'(1) << N_CNT) - REG_W'(1)) << CR2_USR_LSB;

    target_e          tgt;
    logic [IDX_W-1:0] idx;
    cause_e           cause;
    logic [1:0]       mode;
    logic             acc_ok;
    logic             wr_cr0;
    logic             wr_cr2;
    logic [REG_W-1:0] cr0_q;
    logic [REG_W-1:0] cr2_q;
    logic [REG_W-1:0] rd_val;
    logic [REG_W-1:0] rd_q;
    cause_e           cause_q;
    state_e           state_q;
    state_e           state_d;
    logic [N_CNT-1:0] cnt_wr;
    logic [CNT_W-1:0] cnt_val [N_CNT];

    assign mode = cr0_q[MODE_LSB+1:MODE_LSB];

    perfmon_decode #(.N_CNT(N_CNT)) u_decode (
        .num  (req_num),
        .user (req_user),
        .tgt  (tgt),
        .idx  (idx)
    );

    perfmon_gate #(.N_CNT(N_CNT), .WD_LSB(WD_LSB)) u_gate (
        .tgt   (tgt),
        .idx   (idx),
        .user  (req_user),
        .write (req_write),
        .mode  (mode),
        .cause (cause)
    );

    assign acc_ok = req_valid && (cause == CAUSE_NONE);
    assign wr_cr0 = acc_ok && req_write && (tgt == TGT_CR0);
    assign wr_cr2 = acc_ok && req_write && (tgt == TGT_CR2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr0_q <= '0;
            cr2_q <= '0;
        end else begin
            if (wr_cr0) begin
                cr0_q <= req_user ? ((cr0_q & ~CR0_UMASK) | (req_wdata & CR0_UMASK)) : req_wdata;
            end
            if (wr_cr2) begin
                cr2_q <= req_user ? ((cr2_q & ~CR2_UMASK) | (req_wdata & CR2_UMASK)) : req_wdata;
            end
        end
    end

    generate
        for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
            assign cnt_wr[gi] = acc_ok && req_write && (tgt == TGT_CNT) && (idx == IDX_W'(gi));
            perfmon_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (evt[gi]),
                .frz   (cr0_q[FRZ_BIT]),
                .wr_en (cnt_wr[gi]),
                .wdata (req_wdata[CNT_W-1:0]),
                .count (cnt_val[gi])
            );
        end
    endgenerate

    always_comb begin
        rd_val = '0;
        if (!req_write && (cause == CAUSE_NONE)) begin
            unique case (tgt)
                TGT_CR0:  rd_val = req_user ? (cr0_q & CR0_UMASK) : cr0_q;
                TGT_CR2:  rd_val = req_user ? (cr2_q & CR2_UMASK) : cr2_q;
                TGT_CNT: begin
                    for (int i = 0; i < N_CNT; i++) begin
                        if (idx == IDX_W'(i)) rd_val = REG_W'(cnt_val[i]);
                    end
                end
                default:  rd_val = '0;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                rd_q    <= rd_val;
                cause_q <= cause;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_rdata = rd_q;
                rsp_fault = (cause_q != CAUSE_NONE);
                rsp_cause = cause_q;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_rdata = '0;
                rsp_fault = 1'b0;
                rsp_cause = CAUSE_NONE;
            end
        endcase
    end

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R10
    fault_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_rdata == '0));

    // R10
    fault_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> ($stable(cr0_q) && $stable(cr2_q)));

    // R4
    withdrawn_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && (tgt == TGT_CNT) && (int'(idx) >= WD_LSB) && (mode == 2'b11))
        |=> (rsp_fault && (rsp_cause == CAUSE_FACUNAV)));

    // R9
    priv_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user) |=> !rsp_fault);

endmodule

// File: tb/perfmon_access_bench.sv
module perfmon_access_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [7:0]  req_num = '0;
    logic [63:0] req_wdata = '0;
    logic [5:0]  evt = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [63:0] rd;
        logic [1:0]  cause;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    perfmon_access u_perfmon_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_user  (req_user),
        .req_num   (req_num),
        .req_wdata (req_wdata),
        .evt       (evt),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_fault (rsp_fault),
        .rsp_cause (rsp_cause)
    );

    // monitor: compares each response with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R1 unexpected response: actual rdata=%h expected none", rsp_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_rdata !== e.rd || rsp_cause !== e.cause || rsp_fault !== (e.cause != 2'b00)) begin
                    n_fail++;
                    $display("FAIL %s actual rdata=%h cause=%b fault=%b expected rdata=%h cause=%b",
                             e.tag, rsp_rdata, rsp_cause, rsp_fault, e.rd, e.cause);
                end
            end
        end
    end

    task automatic acc(input logic w, input logic u, input logic [7:0] n,
                       input logic [63:0] wd, input logic [5:0] ev,
                       input logic [63:0] erd, input logic [1:0] ec, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_user = u; req_num = n; req_wdata = wd; evt = ev;
        e.rd = erd; e.cause = ec; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_user = 1'b0; evt = '0;
    endtask

    task automatic evt_run(input logic [5:0] m, input int n);
        @(negedge clk);
        evt = m;
        repeat (n) @(negedge clk);
        evt = '0;
    endtask

    localparam logic [1:0] NO = 2'b00, FU = 2'b01, EA = 2'b10;
    localparam logic [63:0] ONES = '1;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_tests++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset state: actual valid=%b fault=%b expected 0 0", rsp_valid, rsp_fault);
        end

        // mode 00
        acc(1, 0, 8'h30, 64'hDEAD_0000_0400_0080, 0, 0, NO, "R9 priv write CR0");
        acc(0, 0, 8'h30, 0, 0, 64'hDEAD_0000_0400_0080, NO, "R9 priv read CR0");
        acc(0, 1, 8'h30, 0, 0, 64'h0000_0000_0400_0080, NO, "R5 R2 user read CR0 mode 00");
        acc(1, 1, 8'h30, ONES, 0, 0, EA, "R3 user write CR0 mode 00");
        acc(0, 0, 8'h30, 0, 0, 64'hDEAD_0000_0400_0080, NO, "R10 CR0 kept after fault");
        acc(1, 1, 8'h32, ONES, 0, 0, EA, "R3 user write CR2 mode 00");
        acc(1, 0, 8'h20, 64'h1234_5678_9ABC_DEF0, 0, 0, NO, "R9 priv write counter1");
        acc(0, 0, 8'h20, 0, 0, 64'h0000_0000_9ABC_DEF0, NO, "R9 priv read counter1");
        acc(0, 1, 8'h10, 0, 0, 64'h0000_0000_9ABC_DEF0, NO, "R8 user read counter1");

        // mode 01
        acc(1, 0, 8'h30, 64'hDEAD_0000_0404_0080, 0, 0, NO, "R9 set mode 01");
        acc(0, 1, 8'h30, 0, 0, 0, FU, "R2 user read CR0 mode 01");
        acc(1, 1, 8'h30, 0, 0, 0, FU, "R3 user write CR0 mode 01");
        acc(0, 1, 8'h12, 0, 0, 0, FU, "R2 user read counter3 mode 01");
        acc(0, 0, 8'h30, 0, 0, 64'hDEAD_0000_0404_0080, NO, "R10 CR0 kept mode 01");

        // mode 10
        acc(1, 0, 8'h30, 64'hDEAD_0000_0408_0080, 0, 0, NO, "R9 set mode 10");
        acc(1, 1, 8'h30, ONES, 0, 0, NO, "R3 user write CR0 mode 10");
        acc(0, 0, 8'h30, 0, 0, 64'hDEAD_0000_8408_0080, NO, "R7 CR0 merge ones");
        acc(1, 1, 8'h30, 0, 0, 0, NO, "R3 user write CR0 zeros");
        acc(0, 0, 8'h30, 0, 0, 64'hDEAD_0000_0008_0000, NO, "R7 CR0 merge zeros");
        acc(1, 0, 8'h32, 64'hF0F0_0000_0000_00F0, 0, 0, NO, "R9 priv write CR2");
        acc(1, 1, 8'h32, ONES, 0, 0, NO, "R3 user write CR2");
        acc(0, 0, 8'h32, 0, 0, 64'hF0F0_0000_0000_3FF0, NO, "R7 CR2 merge");
        acc(0, 1, 8'h32, 0, 0, 64'h0000_0000_0000_3F00, NO, "R6 user read CR2");
        acc(1, 1, 8'h14, 64'h55, 0, 0, NO, "R4 user write counter5 mode 10");
        acc(0, 0, 8'h24, 0, 0, 64'h55, NO, "R8 priv read counter5");
        acc(1, 1, 8'h11, 64'hFFFF_FFFF_0000_0007, 0, 0, NO, "R8 user write counter2");
        acc(0, 0, 8'h21, 0, 0, 64'h7, NO, "R9 counter low 32 bits");

        // mode 11
        acc(1, 0, 8'h30, 64'h0000_0000_000C_0000, 0, 0, NO, "R9 set mode 11");
        acc(0, 1, 8'h14, 0, 0, 0, FU, "R4 user read counter5 mode 11");
        acc(1, 1, 8'h15, 64'h99, 0, 0, FU, "R4 user write counter6 mode 11");
        acc(1, 1, 8'h14, 64'h99, 0, 0, FU, "R4 user write counter5 mode 11");
        acc(0, 0, 8'h24, 0, 0, 64'h55, NO, "R10 R9 counter5 kept, priv ok");
        acc(0, 1, 8'h13, 0, 0, 0, NO, "R4 user read counter4 mode 11");
        acc(1, 1, 8'h10, 64'h3, 0, 0, NO, "R3 user write counter1 mode 11");
        acc(0, 1, 8'h30, 0, 0, 0, NO, "R2 user read CR0 mode 11");

        // unmapped
        acc(0, 1, 8'h77, 0, 0, 0, NO, "R12 user unmapped");
        acc(0, 0, 8'h10, 0, 0, 0, NO, "R12 priv with user number");
        acc(0, 1, 8'h20, 0, 0, 0, NO, "R12 user with priv number");

        // counting
        evt_run(6'b000001, 3);
        acc(0, 0, 8'h20, 0, 0, 64'h6, NO, "R11 counter1 counted");
        acc(0, 0, 8'h21, 0, 0, 64'h7, NO, "R11 counter2 idle");
        acc(1, 0, 8'h30, 64'h0000_0000_800C_0000, 0, 0, NO, "R11 set freeze");
        evt_run(6'b000001, 3);
        acc(0, 0, 8'h20, 0, 0, 64'h6, NO, "R11 frozen counter");
        acc(1, 0, 8'h30, 64'h0000_0000_000C_0000, 0, 0, NO, "R11 clear freeze");
        acc(1, 0, 8'h20, 64'd100, 6'b000001, 0, NO, "R11 write with event");
        acc(0, 0, 8'h20, 0, 0, 64'd100, NO, "R11 write wins");

        repeat (4) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 missing responses: actual pending=%0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog expired: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule